// File: doc/BRIEF.md
# DMA Transfer Counter

This block holds the 24-bit byte count for one DMA transfer. Software programs a start value one byte at a time through three host byte addresses. Issuing a command whose DMA flag is set copies that start value into the live counter. After that, the data path hands in decrement beats, each carrying the number of bytes just moved. The counter counts down toward zero. When a beat takes it from a nonzero value to zero, a terminal-count flag is set and exported for the interrupt logic.

The same three byte addresses read back the live counter. The high byte address is an exception: until software has written it once after reset, a read there returns a fixed identification byte. Drivers use this to probe which chip they are talking to.

Decrement beats arrive on a valid/ready interface. The block applies back-pressure only in a cycle that reloads the counter. In that cycle `dec_ready` is low, so the source must hold its beat, and the beat is applied one cycle later to the freshly loaded value. In every other cycle the beat is taken immediately. Host writes, reads and commands are plain single-cycle strobes.

Top module: `dma_tc_counter`

## Requirements
- R1: After reset the counter is 0, `tc_flag` is 0, all start bytes are 0, and the high-byte written flag is clear. A DMA command issued right after reset therefore loads 0x010000.
- R2: With `rd_addr` 0, 1 or 2, `rd_data` shows counter bits [7:0], [15:8] or [23:16] in the same cycle (subject to R10). `rd_addr` 3 reads 0.
- R3: A host write to address 0, 1 or 2 updates start bits [7:0], [15:8] or [23:16] on the next edge. It never changes the live counter directly. Writes to address 3 have no effect on the start value.
- R4: A cycle with `cmd_valid` high and `cmd_code` bit 7 set loads the counter from the start value as it stood before that cycle's host write. A command with bit 7 clear leaves the counter unchanged.
- R5: A reload whose start value is zero loads 0x010000.
- R6: When `dec_valid` and `dec_ready` are both high, the counter drops by `dec_count`. If `dec_count` is at least the current count, the counter saturates at zero. With no reload and no accepted beat, the counter holds.
- R7: `dec_ready` is low exactly in cycles that reload (R4). The reload takes effect and the held beat is applied in a later cycle to the reloaded value. `dec_ready` is high in every other cycle.
- R8: `tc_flag` is set only when an accepted beat moves the counter from nonzero to zero. A beat that arrives while the counter is already zero does not set it. Once set, it stays set across reloads until R9 or reset clears it.
- R9: A host write to address 0, 1 or 2 clears `tc_flag`. A write to address 3 does not. If a beat reaches zero in the same cycle as a clearing write, `tc_flag` ends up set.
- R10: A read of address 2 returns the `CHIP_ID` parameter until address 2 has been written once after reset. From then on it returns counter bits [23:16]. Reset restores the identification readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| host_wr_en | input | 1 | Host byte write strobe |
| host_addr | input | ADDR_W (2) | Host write address (0 low, 1 mid, 2 high) |
| host_wdata | input | BYTE_W (8) | Host write data |
| rd_addr | input | ADDR_W (2) | Readback address |
| rd_data | output | BYTE_W (8) | Readback byte (combinational) |
| cmd_valid | input | 1 | Command issue strobe |
| cmd_code | input | CMD_W (8) | Command code, bit 7 is the DMA flag |
| dec_valid | input | 1 | Decrement beat valid |
| dec_ready | output | 1 | Decrement beat accepted when high |
| dec_count | input | DEC_W (16) | Bytes moved by this beat |
| count | output | CNT_W (24) | Live counter value |
| tc_flag | output | 1 | Terminal-count status |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a reload and a decrement beat. The bench raises `dec_valid` in the very cycle it issues a DMA command. It then checks that `dec_ready` is low and that the counter takes the start value. It keeps the beat valid, and checks that the count a cycle later is the start value minus the beat.

The second pair is a host write to a counter byte and a beat that drains the counter to zero. The bench drives both together and judges that the flag ends set.

A behavioural reference model follows every clock, so random mixes also produce these collisions and are compared.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int unsigned CMD_BITS = 8;
  localparam int unsigned DMA_FLAG = 7;

  // per-cycle control decision taken by the counter core
  typedef struct packed {
    logic reload;
    logic take;
  } ctl_t;
endpackage

// File: rtl/tc_start_bank.sv
module tc_start_bank #(
  parameter int unsigned NLANES = 3,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [BYTE_W-1:0]          wr_data,
  output logic [NLANES*BYTE_W-1:0]   start_val,
  output logic                       lane_hit,
  output logic                       top_written
);
  localparam logic [ADDR_W-1:0] LAST_LANE = ADDR_W'(NLANES - 1);

  assign lane_hit = wr_en && (wr_addr <= LAST_LANE);

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    lane_q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(g))       lane_q <= wr_data;
    end
    assign start_val[g*BYTE_W +: BYTE_W] = lane_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  top_written <= 1'b0;
    else if (wr_en && wr_addr == LAST_LANE)      top_written <= 1'b1;
  end

  // R10
  top_written_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    top_written |=> top_written);

  // R3
  start_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == '0) |=> start_val[BYTE_W-1:0] == $past(wr_data));
endmodule

// File: rtl/tc_count_core.sv
module tc_count_core
  import dtc_pkg::*;
#(
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned DEC_W     = 16,
  parameter int unsigned CMD_W     = 8,
  parameter int unsigned FLAG_BIT  = 7,
  parameter logic [CNT_W-1:0] ZERO_LOAD = 24'h010000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic [CNT_W-1:0]  start_val,
  input  logic              dec_valid,
  input  logic [DEC_W-1:0]  dec_count,
  input  logic              tc_clear,
  output logic              dec_ready,
  output logic [CNT_W-1:0]  count,
  output logic              tc
);
  ctl_t             ctl;
  logic [CNT_W-1:0] dec_ext;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] sub_val;
  logic             drains;
  logic             tc_set;

  if (DEC_W < CNT_W) begin : g_pad
    assign dec_ext = {{(CNT_W-DEC_W){1'b0}}, dec_count};
  end else begin : g_trim
    assign dec_ext = dec_count[CNT_W-1:0];
  end

  assign ctl.reload = cmd_valid && cmd_code[FLAG_BIT];
  assign dec_ready  = !ctl.reload;
  assign ctl.take   = dec_valid && dec_ready;

  assign load_val = (start_val == '0) ? ZERO_LOAD : start_val;
  assign drains   = (dec_ext >= count);
  assign sub_val  = drains ? '0 : (count - dec_ext);
  assign tc_set   = ctl.take && (count != '0) && drains;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           count <= '0;
    else if (ctl.reload)  count <= load_val;
    else if (ctl.take)    count <= sub_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tc <= 1'b0;
    else if (tc_set)    tc <= 1'b1;
    else if (tc_clear)  tc <= 1'b0;
  end

  // R8
  tc_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc) |-> ($past(count) != '0 && count == '0));

  // R5
  reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code[FLAG_BIT]) |=>
      count == (($past(start_val) == '0) ? ZERO_LOAD : $past(start_val)));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_ready) |=> count <= $past(count));

  // R6
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cmd_valid && cmd_code[FLAG_BIT]) && !(dec_valid && dec_ready)) |=> $stable(count));
endmodule

// File: rtl/tc_readback.sv
module tc_readback #(
  parameter int unsigned NLANES = 3,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ADDR_W = 2,
  parameter logic [BYTE_W-1:0] CHIP_ID = 8'hA2
) (
  input  logic [NLANES*BYTE_W-1:0] count,
  input  logic                     top_written,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [BYTE_W-1:0]        rd_data
);
  localparam logic [ADDR_W-1:0] LAST_LANE = ADDR_W'(NLANES - 1);

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NLANES; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = count[i*BYTE_W +: BYTE_W];
    end
    if (rd_addr == LAST_LANE && !top_written) rd_data = CHIP_ID;
  end
endmodule

// File: rtl/dma_tc_counter.sv
module dma_tc_counter
  import dtc_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DEC_W  = 16,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned CMD_W  = CMD_BITS,
  parameter logic [CNT_W-1:0]  ZERO_LOAD = 24'h010000,
  parameter logic [BYTE_W-1:0] CHIP_ID   = 8'hA2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic              dec_valid,
  output logic              dec_ready,
  input  logic [DEC_W-1:0]  dec_count,
  output logic [CNT_W-1:0]  count,
  output logic              tc_flag
);
  localparam int unsigned NLANES = CNT_W / BYTE_W;

  logic [CNT_W-1:0] start_val;
  logic             lane_hit;
  logic             top_written;

  tc_start_bank #(.NLANES(NLANES), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_start (
    .clk(clk), .rst_n(rst_n),
    .wr_en(host_wr_en), .wr_addr(host_addr), .wr_data(host_wdata),
    .start_val(start_val), .lane_hit(lane_hit), .top_written(top_written)
  );

  tc_count_core #(
    .CNT_W(CNT_W), .DEC_W(DEC_W), .CMD_W(CMD_W),
    .FLAG_BIT(DMA_FLAG), .ZERO_LOAD(ZERO_LOAD)
  ) u_core (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .start_val(start_val),
    .dec_valid(dec_valid), .dec_count(dec_count), .tc_clear(lane_hit),
    .dec_ready(dec_ready), .count(count), .tc(tc_flag)
  );

  tc_readback #(
    .NLANES(NLANES), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .CHIP_ID(CHIP_ID)
  ) u_rd (
    .count(count), .top_written(top_written), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // R9
  tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_hit && !(dec_valid && dec_ready)) |=> !tc_flag);

  // R7
  ready_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> dec_ready);
endmodule

// File: tb/test_dma_tc_counter.sv
`timescale 1ns/1ps
module test_dma_tc_counter;
  localparam int CHIP = 8'hA2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [1:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [1:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_code = '0;
  logic        dec_valid = 1'b0;
  logic        dec_ready;
  logic [15:0] dec_count = '0;
  logic [23:0] count;
  logic        tc_flag;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  dma_tc_counter i_dma_tc_counter (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_addr(host_addr), .host_wdata(host_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_count(dec_count),
    .count(count), .tc_flag(tc_flag)
  );

  // behavioural reference model
  int m_cnt;
  int m_start [3];
  bit m_hiw;
  bit m_tc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_start[0] = 0; m_start[1] = 0; m_start[2] = 0;
      m_hiw = 0; m_tc = 0;
    end else begin
      bit reload, take, setc;
      int old, sv;
      reload = cmd_valid && cmd_code[7];
      take   = dec_valid && !reload;
      old    = m_cnt;
      sv     = m_start[0] + m_start[1] * 256 + m_start[2] * 65536;
      if (reload)    m_cnt = (sv == 0) ? 65536 : sv;
      else if (take) m_cnt = (int'(dec_count) >= m_cnt) ? 0 : m_cnt - int'(dec_count);
      setc = take && old != 0 && m_cnt == 0;
      if (setc) m_tc = 1;
      else if (host_wr_en && host_addr != 2'd3) m_tc = 0;
      if (host_wr_en && host_addr != 2'd3) m_start[host_addr] = int'(host_wdata);
      if (host_wr_en && host_addr == 2'd2) m_hiw = 1;
    end
  end

  function automatic int exp_rd(input int ra);
    case (ra)
      0: return m_cnt % 256;
      1: return (m_cnt / 256) % 256;
      2: return m_hiw ? (m_cnt / 65536) % 256 : CHIP;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit wv, input int wa, input int wd, input bit cv, input int cc,
                     input bit dv, input int dn, input int ra);
    @(negedge clk);
    chk("R6", "count", int'(count), m_cnt);
    chk("R8", "tc_flag", int'(tc_flag), int'(m_tc));
    host_wr_en = wv; host_addr = 2'(wa); host_wdata = 8'(wd);
    cmd_valid = cv; cmd_code = 8'(cc);
    dec_valid = dv; dec_count = 16'(dn); rd_addr = 2'(ra);
    #1;
    chk("R7", "dec_ready", int'(dec_ready), int'(!(cv && cc[7])));
    chk("R2", "rd_data", int'(rd_data), exp_rd(ra));
  endtask

  task automatic idle(input int ra);
    cyc(0, 0, 0, 0, 0, 0, 0, ra);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    host_wr_en = 0; cmd_valid = 0; dec_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    chk("R1", "reset count", int'(count), 0);
    chk("R1", "reset tc", int'(tc_flag), 0);
    chk("R10", "id before write", int'(rd_data), CHIP);

    cyc(0, 0, 0, 1, 8'h90, 0, 0, 0);          // zero start reload
    idle(0);
    chk("R5", "zero start load", int'(count), 24'h010000);

    cyc(0, 0, 0, 1, 8'h10, 0, 0, 0);          // non-DMA command
    idle(0);
    chk("R4", "non-DMA command", int'(count), 24'h010000);

    cyc(1, 0, 8'h05, 0, 0, 0, 0, 2);
    idle(2);
    chk("R3", "write leaves count", int'(count), 24'h010000);
    chk("R10", "id still shown", int'(rd_data), CHIP);

    cyc(1, 2, 8'h00, 0, 0, 0, 0, 2);
    idle(2);
    chk("R10", "high byte after write", int'(rd_data), 8'h01);

    cyc(0, 0, 0, 1, 8'h80, 0, 0, 0);
    idle(0);
    chk("R4", "reload from start", int'(count), 5);

    cyc(0, 0, 0, 0, 0, 1, 2, 0);
    cyc(0, 0, 0, 0, 0, 1, 3, 0);
    idle(0);
    chk("R8", "drain sets tc", int'(tc_flag), 1);
    chk("R6", "drained", int'(count), 0);

    cyc(0, 0, 0, 0, 0, 1, 4, 0);
    idle(0);
    chk("R8", "beat at zero", int'(count), 0);

    cyc(1, 3, 8'h77, 0, 0, 0, 0, 0);
    idle(0);
    chk("R9", "addr 3 keeps tc", int'(tc_flag), 1);
    cyc(1, 1, 8'h01, 0, 0, 0, 0, 0);
    idle(0);
    chk("R9", "counter write clears tc", int'(tc_flag), 0);

    cyc(0, 0, 0, 1, 8'h80, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 16'h0200, 0);
    idle(0);
    chk("R6", "saturate", int'(count), 0);
    chk("R8", "saturate sets tc", int'(tc_flag), 1);

    cyc(0, 0, 0, 1, 8'h80, 0, 0, 0);
    cyc(1, 0, 8'h10, 0, 0, 1, 16'h0105, 0);   // clear and drain together
    idle(0);
    chk("R9", "set beats clear", int'(tc_flag), 1);

    cyc(0, 0, 0, 1, 8'h80, 1, 3, 0);          // reload with beat pending
    chk("R7", "ready low on reload", int'(dec_ready), 0);
    cyc(0, 0, 0, 0, 0, 1, 3, 0);
    chk("R7", "reload won", int'(count), 24'h000110);
    idle(0);
    chk("R7", "held beat applied", int'(count), 24'h00010D);

    cyc(1, 0, 8'h20, 1, 8'h80, 0, 0, 0);
    idle(0);
    chk("R4", "old start used", int'(count), 24'h000110);
    cyc(0, 0, 0, 1, 8'h81, 0, 0, 0);
    idle(0);
    chk("R2", "low byte", int'(rd_data), 8'h20);
    idle(1);
    chk("R2", "mid byte", int'(rd_data), 8'h01);
    idle(3);
    chk("R2", "addr 3 zero", int'(rd_data), 0);

    for (int i = 0; i < 400; i++) begin
      int wa, wd, dn;
      wa = int'($urandom_range(0, 3));
      wd = (wa == 0) ? int'($urandom_range(0, 15)) : (($urandom_range(0, 7) == 0) ? 1 : 0);
      dn = ($urandom_range(0, 9) == 0) ? 300 : int'($urandom_range(0, 5));
      cyc($urandom_range(0, 3) == 0, wa, wd,
          $urandom_range(0, 5) == 0, int'($urandom_range(0, 255)),
          $urandom_range(0, 1) == 1, dn, int'($urandom_range(0, 3)));
    end

    do_reset();
    idle(2);
    chk("R1", "count after reset", int'(count), 0);
    chk("R1", "tc after reset", int'(tc_flag), 0);
    chk("R10", "id restored", int'(rd_data), CHIP);
    cyc(0, 0, 0, 1, 8'h80, 0, 0, 0);
    idle(0);
    chk("R1", "start cleared", int'(count), 24'h010000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule